// File: doc/BRIEF.md
# Six-Mode Gated Interval Counter

This block is a single programmable down-counter channel with a gate input and a waveform output. A host selects one of six behaviours with a 3-bit mode code, chooses binary or four-digit decimal (BCD) counting, and picks how count bytes are delivered: low byte only, high byte only, or low byte followed by high byte. The count value, the output level and a flag telling whether a written value is still waiting to enter the counting register are all visible at the ports. An external latch or read-back unit can sample them from there.

The channel counts on every rising edge of `clk`. The gate input has a different meaning in each mode: a level that enables counting, a rising-edge trigger, or a reload request. The six modes are a one-time terminal-count flag, a retriggerable one-shot, a periodic rate generator, a square-wave generator, a software-started strobe and a gate-started strobe. A written count of zero stands for the largest count: 65536 in binary and 10000 in BCD.

Top module: `gated_interval_counter`

## Requirements
- R1: After reset, `out_level` is 0, `cur_count` is 0 and `null_count` is 0. A mode write stops counting and sets `out_level` to 0 for mode 0 and to 1 for every other mode. Mode codes 0 to 5 select the six modes. Code 6 acts as mode 2 and code 7 acts as mode 3.
- R2: Mode 0 (terminal flag). The completed count N enters `cur_count` one clock after the write that completes it, and `out_level` goes low. The count then decrements on each clock while `gate` is high and holds while `gate` is low. `out_level` goes high in the clock where the count reaches 0, which is N+1 clocks after the completing write when `gate` stays high.
- R3: Mode 1 (one-shot). A rising edge of `gate` loads N and drives `out_level` low for N clocks. A new rising edge during the pulse reloads N and lengthens the pulse. Without a rising edge, `out_level` never falls.
- R4: Mode 2 (rate). `out_level` is low for one clock out of every N, in the clock where the count equals 1, and the count then reloads N. While `gate` is low, counting stops and `out_level` is high one clock later. A rising edge of `gate` reloads N.
- R5: Mode 3 (square). `out_level` is high for ceil(N/2) clocks and low for floor(N/2) clocks, repeating, and the count steps down by 2. Gate handling is the same as in mode 2.
- R6: Mode 4 (software strobe). N clocks after the count enters, with `gate` high, the count reaches 0 and `out_level` is low for exactly one clock. It does not fire again until a new count is written. Counting holds while `gate` is low.
- R7: Mode 5 (gate strobe). A rising edge of `gate` loads N. N clocks later `out_level` is low for exactly one clock. Without a rising edge the count never loads.
- R8: Load format `cfg_fmt`: 01 writes the low byte and clears the high byte, 10 writes the high byte and clears the low byte, 11 takes the low byte and then the high byte, and 00 ignores data writes.
- R9: In format 11, once the low byte is written, the count holds until the high byte arrives.
- R10: With `cfg_bcd` = 1, the count decrements as four BCD digits (0x10 is followed by 0x09).
- R11: A written count of 0 gives 65536 clocks in binary (0 is followed by 0xFFFF) and 10000 clocks in BCD (0 is followed by 0x9999).
- R12: `null_count` rises one clock after a data write and falls one clock after the value enters the counting register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge is a count clock |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | Gate input; its meaning depends on the mode |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_fmt | input | 2 | Byte load format |
| cfg_bcd | input | 1 | 1 selects BCD counting |
| data_we | input | 1 | Count byte write strobe |
| data_in | input | DW | Count byte |
| cur_count | output | 2*DW | Current count register |
| out_level | output | 1 | Channel output |
| null_count | output | 1 | A written value is waiting for transfer |

## Verification
The assertions assume that the host never raises `cfg_we` and `data_we` in the same clock. They assume that counts given to modes 2 and 3 are at least 2. They also assume that BCD counts contain only the digits 0 to 9. Every directed scenario in the bench writes the mode on its own clock before any byte, and uses counts of 3 or more in the periodic modes. The BCD scenario uses decimal values only, so every antecedent of the assertions stays inside these assumptions.

// File: rtl/gic_pkg.sv
package gic_pkg;
  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_t;

  typedef enum logic [1:0] {
    LD_NONE = 2'b00,
    LD_LOW  = 2'b01,
    LD_HIGH = 2'b10,
    LD_BOTH = 2'b11
  } load_fmt_t;

  // codes 110 and 111 fold onto the rate and square modes
  function automatic mode_t norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return mode_t'({1'b0, code[1:0]});
    return mode_t'(code);
  endfunction
endpackage

// File: rtl/gic_step.sv
module gic_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  input  logic [1:0]   amt,
  output logic [W-1:0] res
);
  localparam int DIGITS = W / 4;

  logic [W-1:0]        bin_res;
  logic [W-1:0]        dec_res;
  logic [DIGITS-1:1]   brw;

  assign bin_res = val - W'(amt);

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [4:0] d;
      logic [4:0] sub;
      logic       b_out;
      assign d = {1'b0, val[4*i +: 4]};
      if (i == 0) begin : g_lsd
        assign sub = {3'b000, amt};
      end else begin : g_upper
        assign sub = {4'b0000, brw[i]};
      end
      assign b_out = (d < sub);
      assign dec_res[4*i +: 4] = b_out ? 4'(d + 5'd10 - sub) : 4'(d - sub);
      if (i < DIGITS - 1) begin : g_chain
        assign brw[i+1] = b_out;
      end
    end
  endgenerate

  assign res = bcd ? dec_res : bin_res;
endmodule

// File: rtl/gic_ctrl.sv
module gic_ctrl
  import gic_pkg::*;
#(
  parameter int DW = 8,
  localparam int W = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_mode,
  input  logic [1:0]    cfg_fmt,
  input  logic          cfg_bcd,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          take,
  output mode_t         mode,
  output logic          bcd,
  output logic [W-1:0]  cr,
  output logic          cr_pend,
  output logic          cr_ever,
  output logic          hold,
  output logic          null_count
);
  load_fmt_t     fmt;
  logic          want_high;
  logic [DW-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= M_TERM;
      bcd        <= 1'b0;
      fmt        <= LD_NONE;
      cr         <= '0;
      low_q      <= '0;
      want_high  <= 1'b0;
      hold       <= 1'b0;
      cr_pend    <= 1'b0;
      cr_ever    <= 1'b0;
      null_count <= 1'b0;
    end else if (cfg_we) begin
      mode       <= norm_mode(cfg_mode);
      bcd        <= cfg_bcd;
      fmt        <= load_fmt_t'(cfg_fmt);
      want_high  <= 1'b0;
      hold       <= 1'b0;
      cr_pend    <= 1'b0;
      cr_ever    <= 1'b0;
      null_count <= 1'b0;
    end else if (data_we && fmt != LD_NONE) begin
      null_count <= 1'b1;
      case (fmt)
        LD_LOW: begin
          cr      <= {{DW{1'b0}}, data_in};
          cr_pend <= 1'b1;
          cr_ever <= 1'b1;
        end
        LD_HIGH: begin
          cr      <= {data_in, {DW{1'b0}}};
          cr_pend <= 1'b1;
          cr_ever <= 1'b1;
        end
        default: begin
          if (!want_high) begin
            low_q     <= data_in;
            want_high <= 1'b1;
            hold      <= 1'b1;
          end else begin
            cr        <= {data_in, low_q};
            want_high <= 1'b0;
            hold      <= 1'b0;
            cr_pend   <= 1'b1;
            cr_ever   <= 1'b1;
          end
        end
      endcase
    end else if (take) begin
      cr_pend    <= 1'b0;
      null_count <= hold;
    end
  end

  // R12: any accepted byte raises the flag
  assert_null_on_write_R12: assert property (@(posedge clk) disable iff (rst)
    (data_we && fmt != LD_NONE && !cfg_we) |=> null_count);

  // R8: format 00 leaves the stored value alone
  assert_fmt_none_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (data_we && fmt == LD_NONE && !cfg_we) |=> ($stable(cr) && !null_count));
endmodule

// File: rtl/gic_core.sv
module gic_core
  import gic_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_mode,
  input  mode_t        mode,
  input  logic         bcd,
  input  logic         gate,
  input  logic [W-1:0] cr,
  input  logic         cr_pend,
  input  logic         cr_ever,
  input  logic         hold,
  output logic         take,
  output logic [W-1:0] ce_q,
  output logic         out_q
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic         run_q, gate_q, gate_rise;
  logic [W-1:0] dec1, dec2, ce_n;
  logic         out_n, run_n;

  gic_step #(.W(W)) u_dec1 (.val(ce_q), .bcd(bcd), .amt(2'd1), .res(dec1));
  gic_step #(.W(W)) u_dec2 (.val(ce_q), .bcd(bcd), .amt(2'd2), .res(dec2));

  assign gate_rise = gate && !gate_q;

  always_comb begin
    ce_n  = ce_q;
    out_n = out_q;
    run_n = run_q;
    take  = 1'b0;
    if (cfg_we) begin
      out_n = (norm_mode(cfg_mode) != M_TERM);
      run_n = 1'b0;
    end else begin
      case (mode)
        M_TERM: begin
          if (cr_pend && !hold) begin
            ce_n = cr; out_n = 1'b0; run_n = 1'b1; take = 1'b1;
          end else if (run_q && gate && !hold) begin
            ce_n = dec1;
            if (dec1 == '0) begin out_n = 1'b1; run_n = 1'b0; end
          end
        end
        M_ONESHOT: begin
          if (gate_rise && cr_ever) begin
            ce_n = cr; out_n = 1'b0; run_n = 1'b1; take = cr_pend;
          end else if (run_q && !hold) begin
            ce_n = dec1;
            if (dec1 == '0) begin out_n = 1'b1; run_n = 1'b0; end
          end
        end
        M_RATE: begin
          if (!run_q && cr_pend && !hold) begin
            ce_n = cr; out_n = 1'b1; run_n = 1'b1; take = 1'b1;
          end else if (!gate) begin
            out_n = 1'b1;
          end else if (gate_rise && run_q) begin
            ce_n = cr; out_n = 1'b1; take = cr_pend;
          end else if (run_q && !hold) begin
            if (ce_q == ONE) begin
              ce_n = cr; out_n = 1'b1; take = cr_pend;
            end else begin
              ce_n = dec1; out_n = (dec1 != ONE);
            end
          end
        end
        M_SQUARE: begin
          if (!run_q && cr_pend && !hold) begin
            ce_n = cr; out_n = 1'b1; run_n = 1'b1; take = 1'b1;
          end else if (!gate) begin
            out_n = 1'b1;
          end else if (gate_rise && run_q) begin
            ce_n = cr; out_n = 1'b1; take = cr_pend;
          end else if (run_q && !hold) begin
            if (ce_q == ONE || ce_q == TWO) begin
              out_n = !out_q;
              ce_n  = out_q ? {cr[W-1:1], 1'b0} : cr;
              take  = cr_pend;
            end else begin
              ce_n = dec2;
            end
          end
        end
        M_SWSTROBE: begin
          if (!out_q) out_n = 1'b1;
          if (cr_pend && !hold) begin
            ce_n = cr; out_n = 1'b1; run_n = 1'b1; take = 1'b1;
          end else if (run_q && gate && !hold) begin
            ce_n = dec1;
            if (dec1 == '0) begin out_n = 1'b0; run_n = 1'b0; end
          end
        end
        M_HWSTROBE: begin
          if (!out_q) out_n = 1'b1;
          if (gate_rise && cr_ever) begin
            ce_n = cr; out_n = 1'b1; run_n = 1'b1; take = cr_pend;
          end else if (run_q && !hold) begin
            ce_n = dec1;
            if (dec1 == '0) begin out_n = 1'b0; run_n = 1'b0; end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= '0;
      out_q  <= 1'b0;
      run_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      ce_q   <= ce_n;
      out_q  <= out_n;
      run_q  <= run_n;
      gate_q <= gate;
    end
  end

  function automatic logic bcd_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < W / 4; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2: in mode 0 the output only falls on a count transfer
  assert_term_no_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TERM && out_q && !cfg_we && !take) |=> out_q);

  // R3: the one-shot pulse starts only from a gate rising edge
  assert_oneshot_trigger_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ONESHOT && out_q && !cfg_we && !(gate && !gate_q)) |=> out_q);

  // R4, R5: gate low forces the output high in the periodic modes
  assert_gate_low_high_R4: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_RATE || mode == M_SQUARE) && !gate && !cfg_we) |=> out_q);

  // R6, R7: strobes last exactly one clock
  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_SWSTROBE || mode == M_HWSTROBE) && !out_q && !cfg_we) |=> out_q);

  // R9: a half-written count freezes the level-gated modes
  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (hold && !cfg_we && (mode == M_TERM || mode == M_SWSTROBE)) |=> $stable(ce_q));

  // R10: decimal counting keeps every digit in 0..9
  assert_bcd_digits_R10: assert property (@(posedge clk) disable iff (rst)
    (bcd && bcd_ok(ce_q) && bcd_ok(cr) && !cfg_we) |=> bcd_ok(ce_q));
endmodule

// File: rtl/gated_interval_counter.sv
module gated_interval_counter
  import gic_pkg::*;
#(
  parameter int DW = 8,
  localparam int W = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_mode,
  input  logic [1:0]    cfg_fmt,
  input  logic          cfg_bcd,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  output logic [W-1:0]  cur_count,
  output logic          out_level,
  output logic          null_count
);
  mode_t        mode;
  logic         bcd, cr_pend, cr_ever, hold, take;
  logic [W-1:0] cr;

  gic_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_fmt(cfg_fmt), .cfg_bcd(cfg_bcd), .data_we(data_we),
    .data_in(data_in), .take(take), .mode(mode), .bcd(bcd), .cr(cr),
    .cr_pend(cr_pend), .cr_ever(cr_ever), .hold(hold),
    .null_count(null_count)
  );

  gic_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .mode(mode), .bcd(bcd), .gate(gate), .cr(cr), .cr_pend(cr_pend),
    .cr_ever(cr_ever), .hold(hold), .take(take), .ce_q(cur_count),
    .out_q(out_level)
  );
endmodule

// File: tb/gated_interval_counter_test.sv
module gated_interval_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [1:0]  cfg_fmt = 2'd0;
  logic        cfg_bcd = 1'b0;
  logic        data_we = 1'b0;
  logic [7:0]  data_in = 8'd0;
  logic [15:0] cur_count;
  logic        out_level;
  logic        null_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gated_interval_counter uut (
    .clk(clk), .rst(rst), .gate(gate), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_fmt(cfg_fmt), .cfg_bcd(cfg_bcd), .data_we(data_we), .data_in(data_in),
    .cur_count(cur_count), .out_level(out_level), .null_count(null_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [1:0] f, input logic b);
    cfg_we = 1'b1; cfg_mode = m; cfg_fmt = f; cfg_bcd = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    data_we = 1'b1; data_in = d;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset out", out_level, 0);
    chk("R1 reset count", cur_count, 0);
    chk("R1 reset null", null_count, 0);
  endtask

  task automatic t_mode0;
    gate = 1'b1;
    set_mode(3'd0, 2'b01, 1'b0);
    chk("R1 mode0 write out low", out_level, 0);
    wr(8'd5);
    chk("R12 null set", null_count, 1);
    step(1);
    chk("R12 null cleared", null_count, 0);
    chk("R2 count loaded", cur_count, 5);
    step(4);
    chk("R2 out low before end", out_level, 0);
    chk("R2 count 1", cur_count, 1);
    step(1);
    chk("R2 out high at zero", out_level, 1);
    chk("R2 count 0", cur_count, 0);
    wr(8'd4);
    step(1);
    chk("R2 reload out low", out_level, 0);
    chk("R2 reload count", cur_count, 4);
    gate = 1'b0;
    step(3);
    chk("R2 gate low holds", cur_count, 4);
    gate = 1'b1;
    step(3);
    chk("R2 resume count", cur_count, 1);
    step(1);
    chk("R2 resume out high", out_level, 1);
  endtask

  task automatic t_bytes;
    gate = 1'b1;
    set_mode(3'd0, 2'b11, 1'b0);
    wr(8'h02);
    wr(8'h01);
    step(1);
    chk("R8 two-byte value", cur_count, 16'h0102);
    step(2);
    chk("R8 two-byte counting", cur_count, 16'h0100);
    wr(8'h10);
    chk("R9 low byte edge count", cur_count, 16'h00FF);
    chk("R12 null after low byte", null_count, 1);
    step(3);
    chk("R9 halted after low byte", cur_count, 16'h00FF);
    wr(8'h00);
    chk("R9 halted at high byte", cur_count, 16'h00FF);
    step(1);
    chk("R9 new value after high byte", cur_count, 16'h0010);
    step(15);
    chk("R2 new value count 1", cur_count, 1);
    chk("R2 new value out low", out_level, 0);
    step(1);
    chk("R2 new value out high", out_level, 1);
    set_mode(3'd0, 2'b10, 1'b0);
    wr(8'h01);
    step(1);
    chk("R8 high byte only", cur_count, 16'h0100);
    set_mode(3'd0, 2'b00, 1'b0);
    wr(8'h05);
    step(2);
    chk("R8 format 00 count unchanged", cur_count, 16'h0100);
    chk("R8 format 00 null unchanged", null_count, 0);
    chk("R8 format 00 out unchanged", out_level, 0);
  endtask

  task automatic t_bcd;
    gate = 1'b1;
    set_mode(3'd0, 2'b01, 1'b1);
    wr(8'h10);
    step(1);
    chk("R10 bcd load", cur_count, 16'h0010);
    step(1);
    chk("R10 bcd 10 to 09", cur_count, 16'h0009);
    step(8);
    chk("R10 bcd count 1", cur_count, 16'h0001);
    chk("R10 bcd out low", out_level, 0);
    step(1);
    chk("R10 bcd out high", out_level, 1);
  endtask

  task automatic t_mode1;
    gate = 1'b0;
    set_mode(3'd1, 2'b01, 1'b0);
    chk("R1 mode1 write out high", out_level, 1);
    wr(8'd3);
    step(2);
    chk("R3 no trigger out high", out_level, 1);
    chk("R12 null waits for trigger", null_count, 1);
    gate = 1'b1;
    step(1);
    chk("R3 trigger out low", out_level, 0);
    chk("R3 trigger count", cur_count, 3);
    chk("R12 null cleared on trigger", null_count, 0);
    step(1);
    gate = 1'b0;
    step(1);
    chk("R3 pulse count 1", cur_count, 1);
    gate = 1'b1;
    step(1);
    chk("R3 retrigger reload", cur_count, 3);
    chk("R3 retrigger out low", out_level, 0);
    step(2);
    chk("R3 extended still low", out_level, 0);
    step(1);
    chk("R3 pulse end", out_level, 1);
  endtask

  task automatic t_mode2;
    gate = 1'b1;
    set_mode(3'd2, 2'b01, 1'b0);
    wr(8'd4);
    step(1);
    chk("R4 load", cur_count, 4);
    chk("R4 out high", out_level, 1);
    step(2);
    chk("R4 still high", out_level, 1);
    step(1);
    chk("R4 low at count 1", out_level, 0);
    chk("R4 count 1", cur_count, 1);
    step(1);
    chk("R4 reload", cur_count, 4);
    chk("R4 back high", out_level, 1);
    step(3);
    chk("R4 second pulse", out_level, 0);
    gate = 1'b0;
    step(1);
    chk("R4 gate low forces high", out_level, 1);
    step(2);
    chk("R4 gate low holds", cur_count, 1);
    gate = 1'b1;
    step(1);
    chk("R4 gate rise reload", cur_count, 4);
    step(2);
    chk("R4 after reload", cur_count, 2);
    step(1);
    chk("R4 pulse after reload", out_level, 0);
    set_mode(3'd6, 2'b01, 1'b0);
    wr(8'd3);
    step(2);
    chk("R1 code 6 rate count", cur_count, 2);
    step(1);
    chk("R1 code 6 rate pulse", out_level, 0);
    step(1);
    chk("R1 code 6 rate reload", cur_count, 3);
  endtask

  task automatic t_mode3;
    gate = 1'b1;
    set_mode(3'd7, 2'b01, 1'b0);
    wr(8'd5);
    step(1);
    chk("R5 odd load", cur_count, 5);
    step(2);
    chk("R5 odd high third clock", out_level, 1);
    chk("R5 odd count 1", cur_count, 1);
    step(1);
    chk("R5 odd low phase", out_level, 0);
    chk("R5 odd low reload", cur_count, 4);
    step(1);
    chk("R5 odd low second clock", out_level, 0);
    step(1);
    chk("R5 odd high again", out_level, 1);
    chk("R5 odd high reload", cur_count, 5);
    set_mode(3'd3, 2'b01, 1'b0);
    wr(8'd6);
    step(1);
    chk("R5 even high", out_level, 1);
    step(2);
    chk("R5 even count 2", cur_count, 2);
    step(1);
    chk("R5 even low", out_level, 0);
    step(2);
    chk("R5 even low third clock", out_level, 0);
    step(1);
    chk("R5 even high again", out_level, 1);
  endtask

  task automatic t_mode4;
    gate = 1'b1;
    set_mode(3'd4, 2'b01, 1'b0);
    chk("R1 mode4 write out high", out_level, 1);
    wr(8'd3);
    step(1);
    chk("R6 load", cur_count, 3);
    step(2);
    chk("R6 high before end", out_level, 1);
    step(1);
    chk("R6 strobe low", out_level, 0);
    chk("R6 count 0", cur_count, 0);
    step(1);
    chk("R6 strobe one clock", out_level, 1);
    step(5);
    chk("R6 no repeat out", out_level, 1);
    chk("R6 no repeat count", cur_count, 0);
    gate = 1'b0;
    wr(8'd2);
    step(1);
    chk("R6 gated load", cur_count, 2);
    step(3);
    chk("R6 gate low holds", cur_count, 2);
    gate = 1'b1;
    step(2);
    chk("R6 gated strobe", out_level, 0);
    step(1);
    chk("R6 gated strobe ends", out_level, 1);
  endtask

  task automatic t_mode5;
    gate = 1'b0;
    set_mode(3'd5, 2'b01, 1'b0);
    wr(8'd2);
    step(3);
    chk("R7 no trigger out", out_level, 1);
    chk("R7 no trigger null", null_count, 1);
    gate = 1'b1;
    step(1);
    chk("R7 trigger load", cur_count, 2);
    chk("R12 null cleared on trigger", null_count, 0);
    step(1);
    chk("R7 counting", out_level, 1);
    step(1);
    chk("R7 strobe low", out_level, 0);
    step(1);
    chk("R7 strobe ends", out_level, 1);
  endtask

  task automatic t_max;
    gate = 1'b1;
    set_mode(3'd0, 2'b01, 1'b0);
    wr(8'd0);
    step(1);
    chk("R11 binary zero load", cur_count, 0);
    step(1);
    chk("R11 binary wrap", cur_count, 16'hFFFF);
    step(65534);
    chk("R11 binary count 1", cur_count, 1);
    chk("R11 binary out low", out_level, 0);
    step(1);
    chk("R11 binary out high", out_level, 1);
    set_mode(3'd0, 2'b01, 1'b1);
    wr(8'd0);
    step(2);
    chk("R11 bcd wrap", cur_count, 16'h9999);
    step(9998);
    chk("R11 bcd count 1", cur_count, 1);
    chk("R11 bcd out low", out_level, 0);
    step(1);
    chk("R11 bcd out high", out_level, 1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_mode0();
    t_bytes();
    t_bcd();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_max();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule